// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor with Static Fallback

This block predicts the direction and destination of a branch from its address. It holds branch entries in a set-associative store. Each entry carries a tag, a stored destination and a short local history of that branch's recent outcomes. On a hit, the entry's history selects a saturating counter in a shared pattern table, and that counter gives the direction. On a miss, a fixed rule tree decides the direction from attributes that the decoder supplies with the lookup. Those attributes say whether the branch is relative-addressed, whether it is conditional and whether it points backward. On a miss the decoder's computed destination is returned.

Resolved branches come back through an update port. An update to a known branch shifts its history and trains the counter. An update to an unknown branch claims a way in its set, taking an empty way first and the least-recently-updated way otherwise. The buffer is empty after reset. The lookup answer is registered and appears one cycle after the request.

Top module: `brtarget_pred`

## Requirements
- R1: After reset no entry is valid, so every lookup answers with rsp_hit = 0 until an update has been accepted.
- R2: rsp_valid, rsp_hit, rsp_taken and rsp_target are registered. They describe the lookup presented on the previous rising edge, and rsp_valid is low one cycle after an edge without lk_valid.
- R3: On a miss with lk_rel = 0 (not relative-addressed) the answer is taken, and rsp_target equals lk_calc_tgt.
- R4: On a miss with lk_rel = 1 and lk_cond = 0 (relative, unconditional) the answer is taken, with rsp_target = lk_calc_tgt.
- R5: On a miss with lk_rel = 1 and lk_cond = 1 the answer is taken when lk_back = 1 and not taken when lk_back = 0, with rsp_target = lk_calc_tgt.
- R6: An update to an address with no entry allocates one and always stores up_target. A later lookup of that address hits and returns the stored destination.
- R7: Each entry keeps a 4-bit history. Every update replaces it with {old[2:0], up_taken}, where 1 means taken. A new entry starts from an old history of 0000.
- R8: Direction on a hit comes from bit 1 of a 2-bit counter selected by the entry's history, in a table of 16 counters that reset to 01. An update increments the counter at the entry's pre-update history when taken, saturating at 11, and decrements it when not taken, saturating at 00.
- R9: An update that hits writes up_target only when up_taken = 1. A not-taken update leaves the stored destination unchanged.
- R10: Within a set, empty ways are filled lowest index first. When all 4 ways are valid, the way least recently written by an update is replaced. Lookups do not change recency.
- R11: The set index is address bits [6:0] (128 sets) and the tag is bits [31:7]. An address that differs only in tag, or that maps to another set, does not hit.
- R12: A lookup and an update on the same edge see the state from before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Branch address to predict |
| lk_rel | input | 1 | Branch is relative-addressed |
| lk_cond | input | 1 | Branch is conditional |
| lk_back | input | 1 | Branch destination lies below its address |
| lk_calc_tgt | input | 32 | Destination computed by the decoder, used on a miss |
| rsp_valid | output | 1 | Answer for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_taken | output | 1 | Predicted direction |
| rsp_target | output | 32 | Predicted destination |
| up_valid | input | 1 | Resolved branch update |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved destination |

## Verification
The hardest state to reach is a counter that has saturated and must be observed through a later hit. The pattern table is only visible through the entry whose history points at that counter. The bench therefore drives one branch through a planned run of outcomes. Seven taken updates pin the all-ones history counter at its ceiling, one not-taken update steps it down, and four more taken outcomes walk the history back to all ones, so the lookup shows whether the counter wrapped. Replacement order is exercised by filling one set, re-touching its oldest way, and issuing lookups between updates to show they do not disturb recency.

// File: rtl/brp_pkg.sv
package brp_pkg;

   // Attributes the decoder attaches to a lookup
   typedef struct packed {
      logic rel;    // relative-addressed
      logic cond;   // conditional
      logic back;   // destination below the branch
   } br_attr_t;

   // Which leaf of the static rule tree was reached
   typedef enum logic [1:0] {
      SK_ABSOLUTE = 2'd0,
      SK_UNCOND   = 2'd1,
      SK_BACKWARD = 2'd2,
      SK_FORWARD  = 2'd3
   } static_kind_e;

endpackage

// File: rtl/brp_static_rule.sv
module brp_static_rule
   import brp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  br_attr_t          attr,
   input  logic [ADDR_W-1:0] calc_tgt,
   output logic              taken,
   output logic [ADDR_W-1:0] target
);

   static_kind_e kind;

   always_comb begin
      if (!attr.rel)       kind = SK_ABSOLUTE;
      else if (!attr.cond) kind = SK_UNCOND;
      else if (attr.back)  kind = SK_BACKWARD;
      else                 kind = SK_FORWARD;
   end

   assign taken  = (kind != SK_FORWARD);
   assign target = calc_tgt;

endmodule

// File: rtl/brp_way_match.sv
module brp_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 25,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]      tag,
   output logic                  hit,
   output logic [WAY_W-1:0]      way
);

   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
   end

   always_comb begin
      hit = 1'b0;
      way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (eq[w]) begin
            hit = 1'b1;
            way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/brp_lru.sv
module brp_lru #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS*WAY_W-1:0] rank,
   input  logic [WAY_W-1:0]      touch,
   output logic [WAY_W-1:0]      victim,
   output logic [WAYS*WAY_W-1:0] rank_nxt
);

   // rank 0 = most recently written, WAYS-1 = oldest
   logic              found;
   logic [WAY_W-1:0]  tr;

   always_comb begin
      found  = 1'b0;
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!valid[w] && !found) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++) begin
            if (rank[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
         end
      end
   end

   assign tr = rank[touch*WAY_W +: WAY_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_rank
      always_comb begin
         if (WAY_W'(w) == touch)
            rank_nxt[w*WAY_W +: WAY_W] = '0;
         else if (rank[w*WAY_W +: WAY_W] < tr)
            rank_nxt[w*WAY_W +: WAY_W] = rank[w*WAY_W +: WAY_W] + WAY_W'(1);
         else
            rank_nxt[w*WAY_W +: WAY_W] = rank[w*WAY_W +: WAY_W];
      end
   end

endmodule

// File: rtl/brp_pht.sv
module brp_pht #(
   parameter int HIST_W   = 4,
   parameter int CNT_W    = 2,
   parameter int CNT_INIT = 1,
   localparam int DEPTH   = 1 << HIST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken,
   input  logic              wr_en,
   input  logic [HIST_W-1:0] wr_idx,
   input  logic              wr_taken
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] ctr_q [DEPTH];
   logic [CNT_W-1:0] cur;

   assign rd_taken = ctr_q[rd_idx][CNT_W-1];
   assign cur      = ctr_q[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CNT_W'(CNT_INIT);
      end else if (wr_en) begin
         if (wr_taken && cur != CNT_MAX)   ctr_q[wr_idx] <= cur + CNT_W'(1);
         else if (!wr_taken && cur != '0)  ctr_q[wr_idx] <= cur - CNT_W'(1);
      end
   end

endmodule

// File: rtl/brtarget_pred.sv
module brtarget_pred
   import brp_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int ENTRIES  = 512,
   parameter int WAYS     = 4,
   parameter int HIST_W   = 4,
   parameter int CNT_W    = 2,
   parameter int CNT_INIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_rel,
   input  logic              lk_cond,
   input  logic              lk_back,
   input  logic [ADDR_W-1:0] lk_calc_tgt,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_taken,
   output logic [ADDR_W-1:0] rsp_target,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);

   localparam int SETS  = ENTRIES / WAYS;
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int WAY_W = $clog2(WAYS);

   // ---------------- elaboration checks ----------------
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS * WAYS != ENTRIES || (SETS & (SETS - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be WAYS times a power of two");
   end
   if (HIST_W < 2 || CNT_W < 1) begin : g_bad_hist
      $error("HIST_W must be at least 2 and CNT_W at least 1");
   end
   if (CNT_INIT < 0 || CNT_INIT >= (1 << CNT_W)) begin : g_bad_init
      $error("CNT_INIT must fit in CNT_W bits");
   end

   function automatic logic [WAYS*WAY_W-1:0] rank_reset();
      logic [WAYS*WAY_W-1:0] r;
      for (int w = 0; w < WAYS; w++) r[w*WAY_W +: WAY_W] = WAY_W'(w);
      return r;
   endfunction

   localparam logic [WAYS*WAY_W-1:0] RANK_RST = rank_reset();

   // ---------------- storage ----------------
   logic [WAYS-1:0]       valid_q [SETS];
   logic [WAYS*WAY_W-1:0] rank_q  [SETS];
   logic [HIST_W-1:0]     hist_q  [SETS][WAYS];
   logic [TAG_W-1:0]      tag_q   [SETS][WAYS];
   logic [ADDR_W-1:0]     tgt_q   [SETS][WAYS];

   // ---------------- lookup side ----------------
   logic [IDX_W-1:0]      lk_set;
   logic [TAG_W-1:0]      lk_tag;
   logic [WAYS*TAG_W-1:0] lk_tags;
   logic                  lk_hit;
   logic [WAY_W-1:0]      lk_way;
   logic [HIST_W-1:0]     lk_hist;
   logic                  pht_taken;
   logic                  st_taken;
   logic [ADDR_W-1:0]     st_target;
   br_attr_t              lk_attr;

   assign lk_set  = lk_addr[IDX_W-1:0];
   assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
   assign lk_hist = hist_q[lk_set][lk_way];
   assign lk_attr = '{rel: lk_rel, cond: lk_cond, back: lk_back};

   for (genvar w = 0; w < WAYS; w++) begin : g_lk_tags
      assign lk_tags[w*TAG_W +: TAG_W] = tag_q[lk_set][w];
   end

   brp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
      .valid (valid_q[lk_set]),
      .tags  (lk_tags),
      .tag   (lk_tag),
      .hit   (lk_hit),
      .way   (lk_way)
   );

   brp_static_rule #(.ADDR_W(ADDR_W)) u_static (
      .attr     (lk_attr),
      .calc_tgt (lk_calc_tgt),
      .taken    (st_taken),
      .target   (st_target)
   );

   // ---------------- update side ----------------
   logic [IDX_W-1:0]      up_set;
   logic [TAG_W-1:0]      up_tag;
   logic [WAYS*TAG_W-1:0] up_tags;
   logic                  up_hit;
   logic [WAY_W-1:0]      up_hway;
   logic [WAY_W-1:0]      up_victim;
   logic [WAY_W-1:0]      up_wway;
   logic [WAYS*WAY_W-1:0] up_rank_nxt;
   logic [HIST_W-1:0]     up_old_hist;
   logic [HIST_W-1:0]     up_new_hist;

   assign up_set      = up_addr[IDX_W-1:0];
   assign up_tag      = up_addr[ADDR_W-1:IDX_W];
   assign up_wway     = up_hit ? up_hway : up_victim;
   assign up_old_hist = up_hit ? hist_q[up_set][up_hway] : '0;
   assign up_new_hist = {up_old_hist[HIST_W-2:0], up_taken};

   for (genvar w = 0; w < WAYS; w++) begin : g_up_tags
      assign up_tags[w*TAG_W +: TAG_W] = tag_q[up_set][w];
   end

   brp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
      .valid (valid_q[up_set]),
      .tags  (up_tags),
      .tag   (up_tag),
      .hit   (up_hit),
      .way   (up_hway)
   );

   brp_lru #(.WAYS(WAYS)) u_lru (
      .valid    (valid_q[up_set]),
      .rank     (rank_q[up_set]),
      .touch    (up_wway),
      .victim   (up_victim),
      .rank_nxt (up_rank_nxt)
   );

   brp_pht #(.HIST_W(HIST_W), .CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_pht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_hist),
      .rd_taken (pht_taken),
      .wr_en    (up_valid),
      .wr_idx   (up_old_hist),
      .wr_taken (up_taken)
   );

   // ---------------- state update ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            rank_q[s]  <= RANK_RST;
            for (int w = 0; w < WAYS; w++) hist_q[s][w] <= '0;
         end
      end else if (up_valid) begin
         valid_q[up_set][up_wway] <= 1'b1;
         hist_q[up_set][up_wway]  <= up_new_hist;
         rank_q[up_set]           <= up_rank_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (up_valid) begin
         if (!up_hit)            tag_q[up_set][up_wway] <= up_tag;
         if (!up_hit || up_taken) tgt_q[up_set][up_wway] <= up_target;
      end
   end

   // ---------------- registered answer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_taken  <= 1'b0;
         rsp_target <= '0;
      end else begin
         rsp_valid <= lk_valid;
         if (lk_valid) begin
            rsp_hit    <= lk_hit;
            rsp_taken  <= lk_hit ? pht_taken : st_taken;
            rsp_target <= lk_hit ? tgt_q[lk_set][lk_way] : st_target;
         end
      end
   end

endmodule

// File: rtl/brtarget_pred_chk.sv
module brtarget_pred_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              lk_rel,
   input logic              lk_cond,
   input logic              lk_back,
   input logic [ADDR_W-1:0] lk_calc_tgt,
   input logic              up_valid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_taken,
   input logic [ADDR_W-1:0] rsp_target
);

   logic seen_upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_upd_q <= 1'b0;
      else if (up_valid) seen_upd_q <= 1'b1;
   end

   // R1
   empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !seen_upd_q) |-> !rsp_hit);

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   // R3
   absolute_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_rel) |=>
         (rsp_hit || (rsp_taken && rsp_target == $past(lk_calc_tgt))));

   // R4
   uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_rel && !lk_cond) |=> (rsp_hit || rsp_taken));

   // R5
   backward_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_rel && lk_cond && lk_back) |=> (rsp_hit || rsp_taken));

   // R5
   forward_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_rel && lk_cond && !lk_back) |=> (rsp_hit || !rsp_taken));

endmodule

bind brtarget_pred brtarget_pred_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .lk_rel      (lk_rel),
   .lk_cond     (lk_cond),
   .lk_back     (lk_back),
   .lk_calc_tgt (lk_calc_tgt),
   .up_valid    (up_valid),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_taken   (rsp_taken),
   .rsp_target  (rsp_target)
);

// File: tb/brtarget_pred_tb.sv
module brtarget_pred_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_rel = 1'b0;
   logic        lk_cond = 1'b0;
   logic        lk_back = 1'b0;
   logic [31:0] lk_calc_tgt = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic        rsp_taken;
   logic [31:0] rsp_target;
   logic        up_valid = 1'b0;
   logic [31:0] up_addr = '0;
   logic        up_taken = 1'b0;
   logic [31:0] up_target = '0;

   int n_chk = 0;
   int n_bad = 0;

   logic        g_hit, g_taken;
   logic [31:0] g_tgt;

   always #4 clk = ~clk;   // 125 MHz

   brtarget_pred u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_rel(lk_rel), .lk_cond(lk_cond),
      .lk_back(lk_back), .lk_calc_tgt(lk_calc_tgt),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_target(rsp_target),
      .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken), .up_target(up_target)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic look(input logic [31:0] a, input logic r, input logic c, input logic b,
                       input logic [31:0] calc);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a; lk_rel = r; lk_cond = c; lk_back = b; lk_calc_tgt = calc;
      @(negedge clk);
      lk_valid = 1'b0;
      g_hit = rsp_hit; g_taken = rsp_taken; g_tgt = rsp_target;
   endtask

   task automatic upd(input logic [31:0] a, input logic t, input logic [31:0] tgt);
      @(negedge clk);
      up_valid = 1'b1; up_addr = a; up_taken = t; up_target = tgt;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R2", "rsp_valid after reset", 32'(rsp_valid), 0);
      chk("R1", "rsp_hit after reset", 32'(rsp_hit), 0);
   endtask

   task automatic t_static();
      look(32'h0000_1005, 1'b0, 1'b1, 1'b0, 32'h1111_0000);
      chk("R1", "empty buffer hit", 32'(g_hit), 0);
      chk("R3", "absolute taken", 32'(g_taken), 1);
      chk("R3", "absolute target", g_tgt, 32'h1111_0000);
      chk("R2", "rsp_valid after lookup", 32'(rsp_valid), 1);
      @(negedge clk);
      chk("R2", "rsp_valid idle", 32'(rsp_valid), 0);
      look(32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h2222_0000);
      chk("R4", "uncond taken", 32'(g_taken), 1);
      chk("R4", "uncond target", g_tgt, 32'h2222_0000);
      look(32'h0000_2000, 1'b1, 1'b1, 1'b1, 32'h3333_0000);
      chk("R5", "backward taken", 32'(g_taken), 1);
      look(32'h0000_2000, 1'b1, 1'b1, 1'b0, 32'h4444_0000);
      chk("R5", "forward not taken", 32'(g_taken), 0);
      chk("R5", "forward target", g_tgt, 32'h4444_0000);
   endtask

   task automatic t_history();
      logic [31:0] a = 32'h0000_1005;
      upd(a, 1'b1, 32'hAAAA_0000);                 // ctr0 -> 10, hist 0001
      look(a, 1'b0, 1'b0, 1'b0, 32'h0);
      chk("R6", "hit after allocate", 32'(g_hit), 1);
      chk("R6", "allocated target", g_tgt, 32'hAAAA_0000);
      chk("R8", "ctr[0001]=01 not taken", 32'(g_taken), 0);
      upd(a, 1'b1, 32'hAAAA_0000);                 // hist 0011
      upd(a, 1'b1, 32'hAAAA_0000);                 // hist 0111
      upd(a, 1'b1, 32'hAAAA_0000);                 // hist 1111, ctr15 still 01
      look(a, 1'b0, 1'b0, 1'b0, 32'h0);
      chk("R7", "hist 1111 ctr untrained", 32'(g_taken), 0);
      upd(a, 1'b1, 32'hAAAA_0000);                 // ctr15 -> 10
      look(a, 1'b1, 1'b1, 1'b0, 32'h0);
      chk("R8", "ctr[1111]=10 taken", 32'(g_taken), 1);
      upd(a, 1'b1, 32'hAAAA_0000);                 // ctr15 -> 11
      upd(a, 1'b1, 32'hAAAA_0000);                 // ctr15 stays 11
      upd(a, 1'b0, 32'hBBBB_0000);                 // ctr15 -> 10, hist 1110
      look(a, 1'b0, 1'b0, 1'b0, 32'h0);
      chk("R9", "not-taken keeps target", g_tgt, 32'hAAAA_0000);
      chk("R7", "hist 1110 ctr untrained", 32'(g_taken), 0);
      upd(a, 1'b1, 32'hAAAA_0000);                 // hist 1101
      upd(a, 1'b1, 32'hAAAA_0000);                 // hist 1011
      upd(a, 1'b1, 32'hAAAA_0000);                 // hist 0111
      upd(a, 1'b1, 32'hCCCC_0000);                 // hist 1111
      look(a, 1'b1, 1'b1, 1'b0, 32'h0);
      chk("R8", "saturated ctr stepped to 10", 32'(g_taken), 1);
      chk("R9", "taken update writes target", g_tgt, 32'hCCCC_0000);
   endtask

   task automatic t_replace();
      for (int k = 1; k <= 4; k++) upd(32'h25 | (k << 8), 1'b1, 32'h1000 + k);
      upd(32'h125, 1'b1, 32'h1001);                // refresh way of X1
      look(32'h225, 1'b1, 1'b1, 1'b0, 32'hDEAD);   // lookups must not refresh
      upd(32'h525, 1'b1, 32'h1005);                // evicts X2
      look(32'h125, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      chk("R10", "refreshed entry kept", g_tgt, 32'h1001);
      look(32'h225, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      chk("R10", "oldest entry evicted", 32'(g_hit), 0);
      look(32'h525, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      chk("R10", "new entry present", g_tgt, 32'h1005);
      look(32'h325, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      look(32'h325, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      upd(32'h625, 1'b1, 32'h1006);                // evicts X3 despite lookups
      look(32'h325, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      chk("R10", "looked-up entry still oldest", 32'(g_hit), 0);
      look(32'h425, 1'b1, 1'b1, 1'b0, 32'hDEAD);
      chk("R10", "next entry kept", 32'(g_hit), 1);
   endtask

   task automatic t_index();
      look(32'h0000_1085, 1'b1, 1'b1, 1'b0, 32'h5);
      chk("R11", "same set other tag", 32'(g_hit), 0);
      look(32'h0000_1006, 1'b1, 1'b1, 1'b0, 32'h5);
      chk("R11", "neighbour set", 32'(g_hit), 0);
      look(32'h8000_1005, 1'b1, 1'b1, 1'b0, 32'h5);
      chk("R11", "top tag bit differs", 32'(g_hit), 0);
   endtask

   task automatic t_same_edge();
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = 32'h3040; lk_rel = 1'b1; lk_cond = 1'b1; lk_back = 1'b0;
      lk_calc_tgt = 32'h55;
      up_valid = 1'b1; up_addr = 32'h3040; up_taken = 1'b1; up_target = 32'h77;
      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0;
      chk("R12", "same-edge lookup misses", 32'(rsp_hit), 0);
      chk("R12", "same-edge static target", rsp_target, 32'h55);
      look(32'h3040, 1'b1, 1'b1, 1'b0, 32'h55);
      chk("R12", "following lookup target", g_tgt, 32'h77);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_static();
      t_history();
      t_replace();
      t_index();
      t_same_edge();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule